// File: doc/BRIEF.md
# ATA Transfer Mode Selector

This block picks the transfer timing a host controller should program for one attached ATA drive. It takes the capability fields a drive reports about itself (Ultra DMA, multiword DMA and single-word DMA support masks, the advanced PIO mode mask, the legacy PIO timing number and the minimum cycle time with flow control) and turns them into one DMA mode code and one PIO mode code. Two host-side conditions also shape the result: whether an 80-conductor cable is fitted, and whether DMA is allowed at all.

Host software or a setup sequencer presents the capability fields and pulses `strobe` for one cycle. On the next rising edge both codes are captured, and they stay unchanged until the next strobe. A forced PIO request can override the PIO search. Any value above the fastest supported mode is reduced to that mode.

Top module: `ata_xfer_select`

## Requirements
- R1: The DMA code is chosen by fixed priority. Any Ultra DMA mode beats any multiword mode, and any multiword mode beats any single-word mode. Within a class the highest set mask bit wins. Codes: 0 none, 1..3 single-word 0..2, 4..6 multiword 0..2, 7..11 Ultra DMA 0..4. Mask bit n stands for mode n.
- R2: Ultra DMA modes 3 and 4 (mask bits 3 and 4) are considered only when `cable80` is 1. Without the cable, selection continues with the next lower eligible mode.
- R3: With `dma_en` at 0, or with no eligible mask bit set, the DMA code is 0 and `dma_valid` is 0. Otherwise `dma_valid` is 1.
- R4: With `field_valid` at 0, the Ultra DMA mask, the PIO mode mask and the cycle time are ignored. The multiword and single-word masks still count, and PIO comes from the legacy timing number.
- R5: With `field_valid` at 1 and a nonzero cycle time, the PIO mode is the highest mode k in 0..5 whose cycle time (600, 383, 240, 180, 120 and 100 ns for k = 0..5) is at least the drive's value. A value above 600 gives mode 0.
- R6: With `field_valid` at 1 and a zero cycle time, the PIO mode comes from the mode mask. Bit 2 gives 5, else bit 1 gives 4, else bit 0 gives 3.
- R7: When neither R5 nor R6 applies, a legacy timing number of 2 gives PIO 2, a value of 1 gives PIO 1, and any other value gives PIO 0.
- R8: A PIO result of 0 from R5 to R7 is reported as the slow compatibility code 7 when the legacy timing number is 0. Otherwise it is reported as code 0. PIO codes 0..5 mean modes 0..5.
- R9: With `force_en` at 1, the PIO code is `force_pio` clamped to at most 5, and R5 to R8 do not apply.
- R10: Outputs load the selection one clock after a cycle with `strobe` high. In every other cycle they hold, whatever the inputs do.
- R11: After reset, the DMA code is 0, `dma_valid` is 0 and the PIO code is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Capture the selection on this edge |
| dma_en | input | 1 | DMA allowed |
| cable80 | input | 1 | 80-conductor cable present |
| field_valid | input | 1 | Extended capability fields are valid |
| udma_mask | input | 5 | Ultra DMA support, bit n = mode n |
| mwdma_mask | input | 3 | Multiword DMA support |
| swdma_mask | input | 3 | Single-word DMA support |
| pio_mask | input | 8 | Advanced PIO mask (bits 0..2 used) |
| legacy_pio | input | 8 | Legacy PIO timing number |
| iordy_cycle | input | 16 | Minimum cycle time with flow control, ns |
| force_en | input | 1 | Use the forced PIO request |
| force_pio | input | 4 | Requested PIO mode |
| dma_mode | output | 4 | Chosen DMA code |
| dma_valid | output | 1 | DMA code is not none |
| pio_mode | output | 3 | Chosen PIO code |

## Verification
The assertions assume that `strobe`, `force_en`, `cable80`, `dma_en` and `legacy_pio` are stable at the sampling edge, because the checks that follow a strobe refer to those values. The stimulus changes every input only on falling edges and holds it through the capture edge. Between strobes it changes the inputs freely to test holding. It covers each DMA class alone and in combination, cable gating of the two fastest modes, cycle times at and just past each table boundary, every mask and legacy fallback, and forced values above the clamp.

// File: rtl/ata_mode_pkg.sv
package ata_mode_pkg;
  localparam int PIO_MODES = 6;
  localparam int PIO_W     = 3;
  localparam logic [PIO_W-1:0] PIO_SLOW = 3'd7;
  localparam logic [PIO_W-1:0] PIO_TOP  = 3'd5;

  // minimum cycle time in ns for PIO mode k
  function automatic int unsigned pio_cycle_ns(input int k);
    case (k)
      0: return 600;
      1: return 383;
      2: return 240;
      3: return 180;
      4: return 120;
      default: return 100;
    endcase
  endfunction

  function automatic int code_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ata_dma_prio.sv
module ata_dma_prio #(
  parameter int UDMA_W    = 5,
  parameter int MW_W      = 3,
  parameter int SW_W      = 3,
  parameter int FAST_MIN  = 3,
  parameter int CODE_W    = 4
) (
  input  logic              dma_en,
  input  logic              cable80,
  input  logic              field_valid,
  input  logic [UDMA_W-1:0] udma_mask,
  input  logic [MW_W-1:0]   mwdma_mask,
  input  logic [SW_W-1:0]   swdma_mask,
  output logic [CODE_W-1:0] code
);
  localparam int SW_BASE = 1;
  localparam int MW_BASE = SW_BASE + SW_W;
  localparam int U_BASE  = MW_BASE + MW_W;

  logic [UDMA_W-1:0] u_elig;

  genvar g;
  generate
    for (g = 0; g < UDMA_W; g++) begin : g_gate
      if (g >= FAST_MIN) begin : g_fast
        assign u_elig[g] = udma_mask[g] & cable80 & field_valid;
      end else begin : g_slow
        assign u_elig[g] = udma_mask[g] & field_valid;
      end
    end
  endgenerate

  // scan low to high priority; the last hit wins
  always_comb begin
    code = '0;
    if (dma_en) begin
      for (int i = 0; i < SW_W; i++)
        if (swdma_mask[i]) code = CODE_W'(SW_BASE + i);
      for (int i = 0; i < MW_W; i++)
        if (mwdma_mask[i]) code = CODE_W'(MW_BASE + i);
      for (int i = 0; i < UDMA_W; i++)
        if (u_elig[i]) code = CODE_W'(U_BASE + i);
    end
  end
endmodule

// File: rtl/ata_pio_pick.sv
module ata_pio_pick
  import ata_mode_pkg::*;
#(
  parameter int PMASK_W = 8,
  parameter int TPIO_W  = 8,
  parameter int CYC_W   = 16,
  parameter int REQ_W   = 4
) (
  input  logic               field_valid,
  input  logic [PMASK_W-1:0] pio_mask,
  input  logic [TPIO_W-1:0]  legacy_pio,
  input  logic [CYC_W-1:0]   iordy_cycle,
  input  logic               force_en,
  input  logic [REQ_W-1:0]   force_pio,
  output logic [PIO_W-1:0]   code
);
  logic [PIO_W-1:0] by_cycle, by_mask, by_legacy, raw;
  logic [PIO_MODES-1:0] fits;

  genvar k;
  generate
    for (k = 0; k < PIO_MODES; k++) begin : g_tbl
      assign fits[k] = ({16'd0, iordy_cycle} <= (CYC_W + 16)'(pio_cycle_ns(k)));
    end
  endgenerate

  always_comb begin
    by_cycle = '0;
    for (int i = 0; i < PIO_MODES; i++)
      if (fits[i]) by_cycle = PIO_W'(i);
  end

  always_comb begin
    if (pio_mask[2])      by_mask = 3'd5;
    else if (pio_mask[1]) by_mask = 3'd4;
    else                  by_mask = 3'd3;
  end

  always_comb begin
    if (legacy_pio == TPIO_W'(2))      by_legacy = 3'd2;
    else if (legacy_pio == TPIO_W'(1)) by_legacy = 3'd1;
    else                               by_legacy = 3'd0;
  end

  always_comb begin
    if (field_valid && iordy_cycle != '0)  raw = by_cycle;
    else if (field_valid && |pio_mask[2:0]) raw = by_mask;
    else                                    raw = by_legacy;
  end

  always_comb begin
    if (force_en)
      code = (force_pio > REQ_W'(PIO_TOP)) ? PIO_TOP : PIO_W'(force_pio);
    else if (raw == '0 && legacy_pio == '0)
      code = PIO_SLOW;
    else
      code = raw;
  end
endmodule

// File: rtl/ata_xfer_select.sv
module ata_xfer_select
  import ata_mode_pkg::*;
#(
  parameter int UDMA_W   = 5,
  parameter int MW_W     = 3,
  parameter int SW_W     = 3,
  parameter int FAST_MIN = 3,
  parameter int PMASK_W  = 8,
  parameter int TPIO_W   = 8,
  parameter int CYC_W    = 16,
  parameter int REQ_W    = 4,
  parameter int CODE_W   = code_width(UDMA_W + MW_W + SW_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic               dma_en,
  input  logic               cable80,
  input  logic               field_valid,
  input  logic [UDMA_W-1:0]  udma_mask,
  input  logic [MW_W-1:0]    mwdma_mask,
  input  logic [SW_W-1:0]    swdma_mask,
  input  logic [PMASK_W-1:0] pio_mask,
  input  logic [TPIO_W-1:0]  legacy_pio,
  input  logic [CYC_W-1:0]   iordy_cycle,
  input  logic               force_en,
  input  logic [REQ_W-1:0]   force_pio,
  output logic [CODE_W-1:0]  dma_mode,
  output logic               dma_valid,
  output logic [PIO_W-1:0]   pio_mode
);
  localparam int U_BASE = 1 + SW_W + MW_W;

  logic [CODE_W-1:0] dma_sel;
  logic [PIO_W-1:0]  pio_sel;

  ata_dma_prio #(
    .UDMA_W(UDMA_W), .MW_W(MW_W), .SW_W(SW_W),
    .FAST_MIN(FAST_MIN), .CODE_W(CODE_W)
  ) u_dma (
    .dma_en(dma_en), .cable80(cable80), .field_valid(field_valid),
    .udma_mask(udma_mask), .mwdma_mask(mwdma_mask), .swdma_mask(swdma_mask),
    .code(dma_sel)
  );

  ata_pio_pick #(
    .PMASK_W(PMASK_W), .TPIO_W(TPIO_W), .CYC_W(CYC_W), .REQ_W(REQ_W)
  ) u_pio (
    .field_valid(field_valid), .pio_mask(pio_mask), .legacy_pio(legacy_pio),
    .iordy_cycle(iordy_cycle), .force_en(force_en), .force_pio(force_pio),
    .code(pio_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_mode  <= '0;
      dma_valid <= 1'b0;
      pio_mode  <= PIO_SLOW;
    end else if (strobe) begin
      dma_mode  <= dma_sel;
      dma_valid <= (dma_sel != '0);
      pio_mode  <= pio_sel;
    end
  end

  // R2: no fast Ultra DMA code without the cable
  a_r2_cable_gate: assert property (@(posedge clk) disable iff (rst)
    (strobe && !cable80) |=> (int'(dma_mode) < U_BASE + FAST_MIN));

  // R3: DMA disabled yields none
  a_r3_dma_off: assert property (@(posedge clk) disable iff (rst)
    (strobe && !dma_en) |=> (dma_mode == '0 && !dma_valid));

  // R8: slow code only when the legacy timing number is zero
  a_r8_slow_legacy: assert property (@(posedge clk) disable iff (rst)
    (strobe && !force_en && legacy_pio != '0) |=> (pio_mode != PIO_SLOW));

  // R9: forced request never exceeds the top mode
  a_r9_clamp: assert property (@(posedge clk) disable iff (rst)
    (strobe && force_en) |=> (pio_mode <= PIO_TOP));

  // R10: outputs hold without a strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(dma_mode) && $stable(dma_valid) && $stable(pio_mode)));
endmodule

// File: tb/tb_ata_xfer_select.sv
module tb_ata_xfer_select;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0, dma_en = 1'b0, cable80 = 1'b0, field_valid = 1'b0, force_en = 1'b0;
  logic [4:0]  udma_mask = '0;
  logic [2:0]  mwdma_mask = '0, swdma_mask = '0;
  logic [7:0]  pio_mask = '0, legacy_pio = '0;
  logic [15:0] iordy_cycle = '0;
  logic [3:0]  force_pio = '0;
  logic [3:0]  dma_mode;
  logic        dma_valid;
  logic [2:0]  pio_mode;

  int tests = 0, fails = 0;
  int exp_dma_q[$];
  int exp_pio_q[$];
  string tag_q[$];
  int last_dma = 0, last_pio = 7;
  logic seen = 1'b0;

  always #4 clk = ~clk;

  ata_xfer_select dut (
    .clk(clk), .rst(rst), .strobe(strobe), .dma_en(dma_en), .cable80(cable80),
    .field_valid(field_valid), .udma_mask(udma_mask), .mwdma_mask(mwdma_mask),
    .swdma_mask(swdma_mask), .pio_mask(pio_mask), .legacy_pio(legacy_pio),
    .iordy_cycle(iordy_cycle), .force_en(force_en), .force_pio(force_pio),
    .dma_mode(dma_mode), .dma_valid(dma_valid), .pio_mode(pio_mode)
  );

  function automatic int model_dma();
    if (!dma_en) return 0;
    if (field_valid) begin
      if (udma_mask[4] && cable80) return 11;
      if (udma_mask[3] && cable80) return 10;
      if (udma_mask[2]) return 9;
      if (udma_mask[1]) return 8;
      if (udma_mask[0]) return 7;
    end
    if (mwdma_mask[2]) return 6;
    if (mwdma_mask[1]) return 5;
    if (mwdma_mask[0]) return 4;
    if (swdma_mask[2]) return 3;
    if (swdma_mask[1]) return 2;
    if (swdma_mask[0]) return 1;
    return 0;
  endfunction

  function automatic int model_pio();
    int tbl[6] = '{600, 383, 240, 180, 120, 100};
    int m;
    if (force_en) return (force_pio > 5) ? 5 : int'(force_pio);
    if (field_valid && iordy_cycle != 0) begin
      m = 0;
      for (int k = 5; k >= 0; k--)
        if (int'(iordy_cycle) <= tbl[k]) begin m = k; break; end
    end else if (field_valid && pio_mask[2]) m = 5;
    else if (field_valid && pio_mask[1]) m = 4;
    else if (field_valid && pio_mask[0]) m = 3;
    else if (legacy_pio == 2) m = 2;
    else if (legacy_pio == 1) m = 1;
    else m = 0;
    if (m == 0 && legacy_pio == 0) return 7;
    return m;
  endfunction

  task automatic compare(string tag, int ed, int ep);
    tests++;
    if (int'(dma_mode) != ed || dma_valid != (ed != 0) || int'(pio_mode) != ep) begin
      fails++;
      $display("FAIL %s: dma=%0d valid=%0d pio=%0d expected dma=%0d valid=%0d pio=%0d",
               tag, dma_mode, dma_valid, pio_mode, ed, (ed != 0), ep);
    end
  endtask

  // driver: inputs already set; push expectation and pulse strobe
  task automatic issue(string tag);
    exp_dma_q.push_back(model_dma());
    exp_pio_q.push_back(model_pio());
    tag_q.push_back(tag);
    @(negedge clk) strobe = 1'b1;
    @(negedge clk) strobe = 1'b0;
  endtask

  task automatic caps(logic de, logic c8, logic fv, logic [4:0] u, logic [2:0] mw,
                      logic [2:0] sw, logic [7:0] pm, logic [7:0] lp, logic [15:0] cyc,
                      logic fe, logic [3:0] fp);
    @(negedge clk);
    dma_en = de; cable80 = c8; field_valid = fv; udma_mask = u; mwdma_mask = mw;
    swdma_mask = sw; pio_mask = pm; legacy_pio = lp; iordy_cycle = cyc;
    force_en = fe; force_pio = fp;
  endtask

  always @(posedge clk) seen <= strobe;

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (seen && exp_dma_q.size() > 0) begin
        last_dma = exp_dma_q.pop_front();
        last_pio = exp_pio_q.pop_front();
        compare(tag_q.pop_front(), last_dma, last_pio);
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R11 reset", 0, 7);
    rst = 1'b0;
    // R1 priority across classes
    caps(1,1,1,5'b00111,3'b111,3'b111,0,3,0,0,0); issue("R1 udma2 over mw/sw");
    caps(1,1,1,5'b00000,3'b011,3'b111,0,3,0,0,0); issue("R1 mw1 over sw");
    caps(1,1,1,5'b00000,3'b000,3'b010,0,3,0,0,0); issue("R1 sw1 alone");
    caps(1,1,1,5'b11111,3'b111,3'b111,0,3,0,0,0); issue("R1 udma4 top");
    // R2 cable gating
    caps(1,0,1,5'b11111,3'b111,3'b000,0,3,0,0,0); issue("R2 no cable falls to udma2");
    caps(1,0,1,5'b11000,3'b100,3'b000,0,3,0,0,0); issue("R2 no cable falls to mw2");
    caps(1,1,1,5'b01000,3'b000,3'b000,0,3,0,0,0); issue("R2 cable udma3");
    // R3
    caps(0,1,1,5'b11111,3'b111,3'b111,0,3,0,0,0); issue("R3 dma disabled");
    caps(1,1,1,5'b00000,3'b000,3'b000,0,3,0,0,0); issue("R3 no mask");
    // R4
    caps(1,1,0,5'b11111,3'b010,3'b000,8'h07,2,100,0,0); issue("R4 field invalid");
    // R5 table boundaries
    caps(0,0,1,0,0,0,8'h07,0,100,0,0); issue("R5 cyc 100");
    caps(0,0,1,0,0,0,0,0,101,0,0); issue("R5 cyc 101");
    caps(0,0,1,0,0,0,0,0,180,0,0); issue("R5 cyc 180");
    caps(0,0,1,0,0,0,0,0,383,0,0); issue("R5 cyc 383");
    caps(0,0,1,0,0,0,0,1,600,0,0); issue("R5 cyc 600");
    caps(0,0,1,0,0,0,0,1,601,0,0); issue("R5 cyc 601");
    // R6 mask
    caps(0,0,1,0,0,0,8'h04,0,0,0,0); issue("R6 mask bit2");
    caps(0,0,1,0,0,0,8'h02,0,0,0,0); issue("R6 mask bit1");
    caps(0,0,1,0,0,0,8'h01,0,0,0,0); issue("R6 mask bit0");
    // R7 legacy
    caps(0,0,1,0,0,0,8'h00,2,0,0,0); issue("R7 legacy 2");
    caps(0,0,1,0,0,0,8'h00,1,0,0,0); issue("R7 legacy 1");
    caps(0,0,1,0,0,0,8'h00,9,0,0,0); issue("R7 legacy 9");
    // R8 slow mapping
    caps(0,0,1,0,0,0,8'h00,0,0,0,0); issue("R8 slow");
    caps(0,0,1,0,0,0,8'h00,0,700,0,0); issue("R8 slow from cycle");
    // R9 forced clamp
    caps(0,0,1,0,0,0,8'h04,0,0,1,4'd9); issue("R9 clamp 9");
    caps(0,0,1,0,0,0,8'h04,0,0,1,4'd2); issue("R9 force 2");
    caps(0,0,1,0,0,0,8'h00,0,0,1,4'd0); issue("R9 force 0 not slow");
    // R10 hold: change inputs without strobe
    caps(1,1,1,5'b11111,3'b111,3'b111,8'h04,2,100,0,0);
    repeat (3) @(negedge clk);
    compare("R10 hold", last_dma, last_pio);
    issue("R10 load after hold");
    repeat (3) @(negedge clk);
    if (exp_dma_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R10 pending: actual=%0d expected=0", exp_dma_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule